// File: doc/BRIEF.md
# Microprogram Sequencer with Return/Loop Stack

This block works out the fetch address of the next microinstruction for a microcoded control unit. Each cycle it sends an address `uaddr` to an external control store. It takes the returned microword into its own pipeline register. The word in that register is the one that executes: its control field leaves the block on `ctl`, and its sequencing fields pick where the next fetch comes from. Fetching the next word therefore overlaps with executing the current one.

The next address can come from several sources:
- the incremented address,
- a target field in the executing microword,
- an entry point computed from the instruction opcode,
- an external vector,
- the top of a six-entry hardware stack.

The stack holds subroutine return addresses and loop start addresses. A loop counter lets a body repeat with no branch in the body itself. Datapath flags are registered before they are tested, so a conditional branch sees the flags from the previous cycle. Any taken branch cancels the one sequential word that has already been fetched. That word becomes an all-zero no-op, which costs one bubble cycle.

Top module: `useq_ctl`

## Requirements
- R1: A synchronous active-high reset sets `uaddr` to 0, the pipeline register to the all-zero no-op (`ctl`=0), the stack to empty, the loop counter and status register to 0, and `err` to 0.
- R2: The 23-bit microword is laid out as follows: target [7:0], sequence code [10:8], flag select [12:11], polarity [13], loop-begin [14], control [22:15]. The sequence codes are 0 continue, 1 jump, 2 conditional jump, 3 opcode map, 4 call, 5 return, 6 loop end, 7 vector. With code 0 and no interrupt, `uaddr` rises by one per cycle, and `ctl` shows the control field of the word fetched in the previous cycle.
- R3: Code 1 makes the next `uaddr` equal the target. On the following cycle `ctl` reads 0, because the word already fetched is cancelled.
- R4: Code 2 branches to the target when status[select] XOR polarity is 1. Otherwise it continues. The status register holds the flag inputs sampled at the previous clock edge, not the current inputs.
- R5: Code 3 makes the next `uaddr` equal `opcode` shifted left by 3, then cancels the fetched word.
- R6: Code 4 pushes the current `uaddr` (the address after the call) and jumps to the target. Code 5 jumps to the top entry and pops it. Six nested calls are held and return in last-in-first-out order.
- R7: A code-0 word with loop-begin set pushes the current `uaddr` and loads the loop counter from its target field. Code 6 does one of two things. With a nonzero counter it decrements the counter and jumps to the top entry without popping. With a zero counter it pops and continues. A body loaded with N runs N+1 times.
- R8: Code 7 jumps to `vec`. When `irq` is high while a code-0 word without loop-begin executes, the block pushes the current `uaddr` and jumps to `vec`, and a later return resumes at that address.
- R9: A call or loop-begin on a full stack, or a return or loop end on an empty stack, sets `err`. `err` stays set until reset, and the stack contents are not changed. A call still jumps. A return then continues sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uword | input | 23 | Microword read from the control store at `uaddr` |
| opcode | input | 4 | Opcode field of the instruction register |
| flags | input | 4 | Datapath status flags |
| irq | input | 1 | Interrupt request |
| vec | input | 8 | Interrupt / vector target address |
| uaddr | output | 8 | Fetch address for the control store |
| ctl | output | 8 | Control field of the executing microword |
| err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The embedded properties assume three things. The control store returns the word for `uaddr` within the same cycle. `opcode` and `vec` are settled by the clock edge at which the map or vector word executes. `irq` is raised only for as long as the requester wants one entry. The bench meets these with a combinational store model. It changes `opcode`, `vec` and `flags` only at falling edges, and it pulses `irq` for exactly one cycle while a plain sequential word is executing. Over- and underflow are provoked on purpose in one directed program. Every other program keeps the stack within six entries.

// File: rtl/useq_ctl.sv
module useq_ctl #(
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int NF    = 4,
  parameter int DEPTH = 6,
  parameter int OPW   = 4,
  parameter int MAPSH = 3,
  localparam int SW   = $clog2(NF),
  localparam int MW   = CW + AW + SW + 5,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] uword,
  input  logic [OPW-1:0] opcode,
  input  logic [NF-1:0] flags,
  input  logic          irq,
  input  logic [AW-1:0] vec,
  output logic [AW-1:0] uaddr,
  output logic [CW-1:0] ctl,
  output logic          err
);

  localparam logic [2:0] S_CONT = 3'd0, S_JMP = 3'd1, S_CJMP = 3'd2, S_MAP = 3'd3,
                         S_CALL = 3'd4, S_RET = 3'd5, S_LEND = 3'd6, S_VEC = 3'd7;

  logic [AW-1:0] upc, cnt, nxt, tgt, top;
  logic [MW-1:0] pl;
  logic [NF-1:0] stat;
  logic [AW-1:0] stk [DEPTH];
  logic [PW-1:0] sp;
  logic [2:0]    seq;
  logic [SW-1:0] csel;
  logic          pol, lpb, empty, full;
  logic          cancel, push, pop, ld, dec, bad;

  assign uaddr = upc;
  assign ctl   = pl[MW-1 -: CW];
  assign tgt   = pl[AW-1:0];
  assign seq   = pl[AW+2:AW];
  assign csel  = pl[AW+3 +: SW];
  assign pol   = pl[AW+3+SW];
  assign lpb   = pl[AW+4+SW];
  assign empty = (sp == '0);
  assign full  = (sp == PW'(DEPTH));
  assign top   = empty ? '0 : stk[sp - 1'b1];

  always_comb begin
    nxt = upc + 1'b1;
    cancel = 1'b0; push = 1'b0; pop = 1'b0;
    ld = 1'b0; dec = 1'b0; bad = 1'b0;
    case (seq)
      S_CONT: if (lpb) begin
                push = 1'b1; ld = 1'b1;
              end else if (irq) begin
                nxt = vec; cancel = 1'b1; push = 1'b1;
              end
      S_JMP:  begin nxt = tgt; cancel = 1'b1; end
      S_CJMP: if (stat[csel] ^ pol) begin nxt = tgt; cancel = 1'b1; end
      S_MAP:  begin nxt = AW'(opcode) << MAPSH; cancel = 1'b1; end
      S_CALL: begin nxt = tgt; cancel = 1'b1; push = 1'b1; end
      S_RET:  if (empty) bad = 1'b1;
              else begin nxt = top; cancel = 1'b1; pop = 1'b1; end
      S_LEND: if (empty) bad = 1'b1;
              else if (cnt != '0) begin nxt = top; cancel = 1'b1; dec = 1'b1; end
              else pop = 1'b1;
      S_VEC:  begin nxt = vec; cancel = 1'b1; end
    endcase
    if (push && full) begin
      push = 1'b0; bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upc  <= '0;
      pl   <= '0;
      stat <= '0;
      sp   <= '0;
      cnt  <= '0;
      err  <= 1'b0;
    end else begin
      upc  <= nxt;
      pl   <= cancel ? '0 : uword;
      stat <= flags;
      if (bad) err <= 1'b1;
      if (push) sp <= sp + 1'b1;
      else if (pop) sp <= sp - 1'b1;
      if (ld) cnt <= tgt;
      else if (dec) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && push) stk[sp] <= upc;
  end

  // R2
  seq_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (seq == S_CONT && !irq) |=> uaddr == $past(uaddr) + 1'b1);

  // R3
  jump_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (seq == S_JMP) |=> (uaddr == $past(tgt) && ctl == '0));

  // R5
  map_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (seq == S_MAP) |=> uaddr == (AW'($past(opcode)) << MAPSH));

  // R7
  loop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (seq == S_LEND && !empty && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seq == S_CALL && full) |=> (full && err));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

endmodule

// File: tb/test_useq_ctl.sv
module test_useq_ctl;
  localparam int CLK_P = 10;
  localparam int MW = 23;

  logic clk = 1'b0, rst = 1'b1, irq = 1'b0, err;
  logic [MW-1:0] uword;
  logic [3:0] opcode = '0, flags = '0;
  logic [7:0] vec = '0, uaddr, ctl;
  logic [MW-1:0] rom [0:255];
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;
  assign uword = rom[uaddr];

  useq_ctl i_useq_ctl (.clk(clk), .rst(rst), .uword(uword), .opcode(opcode), .flags(flags),
                       .irq(irq), .vec(vec), .uaddr(uaddr), .ctl(ctl), .err(err));

  // entries: {req, expected uaddr, expected ctl}, one per cycle after release of reset
  localparam logic [19:0] TRACE [0:25] = '{
    20'h2_01_80, 20'h2_02_81, 20'h2_03_82,             // R2 sequential
    20'h3_0A_00, 20'h3_0B_8A,                          // R3 jump with bubble
    20'h7_0C_8B, 20'h7_0D_8C, 20'h7_0B_00, 20'h7_0C_8B, // R7 loop body x3
    20'h7_0D_8C, 20'h7_0B_00, 20'h7_0C_8B, 20'h7_0D_8C,
    20'h7_0E_8D,
    20'h6_14_00, 20'h6_15_94, 20'h6_16_95, 20'h6_0E_00, // R6 call/return
    20'h6_0F_8E,
    20'h4_1E_00, 20'h4_1F_9E,                          // R4 taken on registered flag
    20'h5_28_00, 20'h5_29_A8,                          // R5 opcode map
    20'h8_32_00, 20'h8_33_B2,                          // R8 vector
    20'h2_34_B3
  };

  function automatic logic [MW-1:0] mk(input logic [2:0] s, input logic [7:0] t,
      input logic [1:0] cs, input logic p, input logic lb, input logic [7:0] tag);
    return {tag, lb, p, cs, s, t};
  endfunction

  task automatic clear_rom();
    for (int a = 0; a < 256; a++) rom[a] = mk(3'd0, 8'd0, 2'd0, 1'b0, 1'b0, {1'b1, 7'(a)});
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_to(input logic [7:0] a, output logic hit);
    hit = 1'b0;
    for (int k = 0; k < 20 && !hit; k++) begin
      @(negedge clk);
      if (uaddr == a) hit = 1'b1;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic hit;
    // main program
    clear_rom();
    rom[2]  = mk(3'd1, 8'd10, 2'd0, 1'b0, 1'b0, 8'h82);
    rom[10] = mk(3'd0, 8'd2,  2'd0, 1'b0, 1'b1, 8'h8A);
    rom[12] = mk(3'd6, 8'd0,  2'd0, 1'b0, 1'b0, 8'h8C);
    rom[13] = mk(3'd4, 8'd20, 2'd0, 1'b0, 1'b0, 8'h8D);
    rom[14] = mk(3'd2, 8'd30, 2'd1, 1'b0, 1'b0, 8'h8E);
    rom[21] = mk(3'd5, 8'd0,  2'd0, 1'b0, 1'b0, 8'h95);
    rom[30] = mk(3'd3, 8'd0,  2'd0, 1'b0, 1'b0, 8'h9E);
    rom[40] = mk(3'd7, 8'd0,  2'd0, 1'b0, 1'b0, 8'hA8);
    opcode = 4'd5; vec = 8'd50; flags = 4'b0010;
    do_reset();
    // R1 reset state
    chk("R1", {uaddr, ctl}, 16'h0000);
    chk("R1", {15'd0, err}, 16'd0);
    for (int i = 0; i < 26; i++) begin
      @(negedge clk);
      chk($sformatf("R%0d", TRACE[i][19:16]), {uaddr, ctl}, TRACE[i][15:0]);
    end
    chk("R9", {15'd0, err}, 16'd0);

    // R4: flags tested one cycle late, both polarities
    clear_rom();
    rom[0]  = mk(3'd2, 8'd30, 2'd2, 1'b0, 1'b0, 8'h80);
    rom[2]  = mk(3'd2, 8'd30, 2'd2, 1'b0, 1'b0, 8'h82);
    rom[31] = mk(3'd2, 8'd60, 2'd2, 1'b1, 1'b0, 8'h9F);
    flags = 4'b0000;
    do_reset();
    @(negedge clk); flags = 4'b0100;
    @(negedge clk); chk("R4", {uaddr, ctl}, 16'h0281);
    @(negedge clk); chk("R4", {uaddr, ctl}, 16'h0382);
    @(negedge clk); chk("R4", {uaddr, ctl}, 16'h1E00);
    @(negedge clk); chk("R4", {uaddr, ctl}, 16'h1F9E);
    @(negedge clk); chk("R4", {uaddr, ctl}, 16'h209F);
    @(negedge clk); chk("R4", {uaddr, ctl}, 16'h21A0);

    // R8: interrupt pushes return address and jumps to vector
    clear_rom();
    rom[51] = mk(3'd5, 8'd0, 2'd0, 1'b0, 1'b0, 8'hB3);
    vec = 8'd50;
    do_reset();
    repeat (3) @(negedge clk);
    chk("R8", {uaddr, ctl}, 16'h0382);
    irq = 1'b1;
    @(negedge clk); irq = 1'b0; chk("R8", {uaddr, ctl}, 16'h3200);
    @(negedge clk); chk("R8", {uaddr, ctl}, 16'h33B2);
    @(negedge clk); chk("R8", {uaddr, ctl}, 16'h34B3);
    @(negedge clk); chk("R8", {uaddr, ctl}, 16'h0300);
    @(negedge clk); chk("R8", {uaddr, ctl}, 16'h0483);

    // R6 / R9: six nested calls, a seventh overflows, then unwind
    clear_rom();
    for (int j = 0; j < 7; j++)
      rom[j*10] = mk(3'd4, 8'(j*10 + 10), 2'd0, 1'b0, 1'b0, {1'b1, 7'(j*10)});
    for (int j = 0; j < 6; j++)
      rom[j*10 + 1] = mk(3'd5, 8'd0, 2'd0, 1'b0, 1'b0, {1'b1, 7'(j*10 + 1)});
    rom[70] = mk(3'd5, 8'd0, 2'd0, 1'b0, 1'b0, 8'hC6);
    do_reset();
    run_to(8'd60, hit); chk("R6", {15'd0, hit}, 16'd1);
    chk("R6", {15'd0, err}, 16'd0);
    run_to(8'd70, hit); chk("R9", {15'd0, hit}, 16'd1);
    chk("R9", {15'd0, err}, 16'd1);
    for (int j = 5; j >= 0; j--) begin
      run_to(8'(j*10 + 1), hit);
      chk("R6", {15'd0, hit}, 16'd1);
    end
    repeat (2) @(negedge clk);
    chk("R9", {uaddr, 7'd0, err}, 16'h0301);

    // R1: reset clears err and leaves an empty stack
    clear_rom();
    rom[0] = mk(3'd5, 8'd0, 2'd0, 1'b0, 1'b0, 8'h80);
    do_reset();
    chk("R1", {uaddr, ctl}, 16'h0000);
    chk("R1", {15'd0, err}, 16'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R1", {uaddr, ctl}, 16'h0281);
    chk("R9", {15'd0, err}, 16'd1);

    summary();
    $finish;
  end
endmodule